// File: doc/BRIEF.md
# Boot-Overlay Chip-Select Decoder With Wait-State Insertion

This block turns a 24-bit processor address into one of four mutually exclusive chip selects (boot PROM, interrupt controller, I/O window, ordinary RAM). While a bus cycle is in progress it also drives a ready signal that holds the processor for a configurable number of wait states, with a separate count for each region. Outside a bus cycle every select and ready stay low.

Two memory maps are built in. The standard map places the PROM high in memory and adds a boot overlay. Reset arms the overlay, and while it is armed the PROM answers at every address. The overlay is disarmed when the first write cycle completes. The alternate map places the PROM at the bottom of memory and the I/O window at C00000h, and it ignores the overlay. In the alternate map the interrupt-controller select is also qualified by address bit 8. This lets the normal-interrupt vector fetch at FFFE00h reach the controller while the non-maskable vector fetch at FFFF00h falls through to RAM. The map is taken either from a mode pin or from a fixed parameter.

A cycle starts when `cyc_i` rises, or in the cycle after ready was given while `cyc_i` stays high. The address and write indication are held stable until ready.

Top module: `bootmap_decoder`

## Requirements
- R1: While `cyc_i` is low, all four selects and `ready_o` are low.
- R2: In the standard map, while the boot overlay is armed, every address selects the PROM. Reset arms the overlay.
- R3: The overlay is disarmed by the clock edge at which a write cycle is given ready (`cyc_i`, `wr_i` and `ready_o` all high). Read cycles leave it armed.
- R4: Standard map with the overlay disarmed: FFF800h–FFFFFFh selects the interrupt controller, FF0000h–FF7FFFh the PROM, FE0000h–FEFFFFh and FF8000h–FFEFFFh the I/O window, and every other address RAM.
- R5: Standard-map wait states are `STD_ROM_WAIT` for the PROM, `STD_ICU_WAIT` for the interrupt controller, `STD_IO_WAIT` for I/O (all default 1), and 0 for RAM.
- R6: Alternate map: the PROM is selected when bits 23–19 and 17–15 are all zero, with bit 18 ignored so 040000h aliases 000000h. I/O is selected when bits 23–22 are one and bits 21–16 are zero (C00000h–C0FFFFh).
- R7: In the alternate map the interrupt controller is selected only for addresses FFF800h–FFFFFFh that have bit 8 low. FFFE00h selects it, and FFFF00h selects RAM.
- R8: The alternate map ignores the boot overlay. Its interrupt controller and RAM take zero wait states, the PROM takes `ALT_ROM_WAIT`, and I/O takes `ALT_IO_WAIT`.
- R9: During a bus cycle exactly one select is high. Precedence is overlay PROM, then interrupt controller, then I/O, then PROM, then RAM.
- R10: A region with wait count n gives `ready_o` high exactly n cycles after the cycle starts. With n = 0, ready is high in the first cycle.
- R11: With `MAP_FROM_PIN` = 1, `alt_i` = 1 picks the alternate map. With `MAP_FROM_PIN` = 0, `alt_i` is ignored and `FIXED_ALT` picks the map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset; arms the boot overlay |
| addr_i | input | 24 | Bus address |
| cyc_i | input | 1 | Bus-cycle strobe, held until ready |
| wr_i | input | 1 | High for a write cycle |
| alt_i | input | 1 | Map select pin (1 = alternate map) |
| sel_rom_o | output | 1 | PROM select |
| sel_icu_o | output | 1 | Interrupt-controller select |
| sel_io_o | output | 1 | I/O window select |
| sel_ram_o | output | 1 | RAM select |
| ready_o | output | 1 | Cycle may end this clock |

## Verification
The bench builds two instances. The first takes its map from the pin and uses the default wait of one for each non-RAM region, so both maps and the overlay can be exercised under pin control. The second fixes the alternate map while its pin is driven to the opposite value. It gives the PROM no wait and the I/O window two waits, which exercises the zero-wait PROM path, the multi-step countdown and parameter precedence over the pin.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

    localparam int ADDR_W = 24;

    typedef enum logic [1:0] {
        RG_RAM = 2'd0,
        RG_ROM = 2'd1,
        RG_ICU = 2'd2,
        RG_IO  = 2'd3
    } region_e;

    typedef struct packed {
        logic armed;
    } boot_state_t;

endpackage

// File: rtl/bmd_region_decode.sv
module bmd_region_decode
    import bmd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              alt_i,
    input  logic              boot_i,
    output region_e           region_o
);

    logic std_icu, std_rom, std_io;
    logic alt_icu, alt_rom, alt_io;
    logic hit_icu, hit_rom, hit_io;
    logic unused_addr_bits;

    assign unused_addr_bits = ^{addr_i[10:9], addr_i[7:0]};

    always_comb begin
        // standard map
        std_icu = &addr_i[23:11];
        std_rom = (addr_i[23:16] == 8'hFF) && !addr_i[15];
        std_io  = (addr_i[23:16] == 8'hFE)
               || ((addr_i[23:16] == 8'hFF) && addr_i[15] && (addr_i[14:12] != 3'b111));
        // alternate map, bit 18 left out of the PROM term on purpose
        alt_icu = (&addr_i[23:11]) && !addr_i[8];
        alt_io  = (addr_i[23:22] == 2'b11) && (addr_i[21:16] == 6'd0);
        alt_rom = (addr_i[23:19] == 5'd0) && (addr_i[17:15] == 3'd0);

        hit_icu = alt_i ? alt_icu : std_icu;
        hit_io  = alt_i ? alt_io  : std_io;
        hit_rom = alt_i ? alt_rom : std_rom;

        if (!alt_i && boot_i)  region_o = RG_ROM;
        else if (hit_icu)      region_o = RG_ICU;
        else if (hit_io)       region_o = RG_IO;
        else if (hit_rom)      region_o = RG_ROM;
        else                   region_o = RG_RAM;
    end

endmodule

// File: rtl/bmd_boot_flag.sv
module bmd_boot_flag
    import bmd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cyc_i,
    input  logic wr_i,
    input  logic ready_i,
    output logic boot_o
);

    boot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cyc_i && wr_i && ready_i) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{armed: 1'b1};
        else         st_q <= st_d;
    end

    assign boot_o = st_q.armed;

endmodule

// File: rtl/bmd_wait_seq.sv
module bmd_wait_seq #(
    parameter int MAX_WAIT = 3,
    localparam int WAIT_W  = $clog2(MAX_WAIT + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cyc_i,
    input  logic [WAIT_W-1:0] wait_i,
    output logic              ready_o
);

    typedef struct packed {
        logic              active;
        logic [WAIT_W-1:0] cnt;
    } wait_state_t;

    wait_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        ready_o = 1'b0;
        if (!cyc_i) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (!st_q.active) begin
            if (wait_i == '0) begin
                ready_o = 1'b1;
            end else begin
                st_d.active = 1'b1;
                st_d.cnt    = wait_i - 1'b1;
            end
        end else if (st_q.cnt == '0) begin
            ready_o     = 1'b1;
            st_d.active = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder
    import bmd_pkg::*;
#(
    parameter bit MAP_FROM_PIN = 1'b1,
    parameter bit FIXED_ALT    = 1'b0,
    parameter int MAX_WAIT     = 3,
    parameter int STD_ROM_WAIT = 1,
    parameter int STD_ICU_WAIT = 1,
    parameter int STD_IO_WAIT  = 1,
    parameter int ALT_ROM_WAIT = 1,
    parameter int ALT_IO_WAIT  = 1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [23:0] addr_i,
    input  logic        cyc_i,
    input  logic        wr_i,
    input  logic        alt_i,
    output logic        sel_rom_o,
    output logic        sel_icu_o,
    output logic        sel_io_o,
    output logic        sel_ram_o,
    output logic        ready_o
);

    localparam int WAIT_W = $clog2(MAX_WAIT + 1);
    localparam logic [WAIT_W-1:0] W_STD_ROM = WAIT_W'(STD_ROM_WAIT);
    localparam logic [WAIT_W-1:0] W_STD_ICU = WAIT_W'(STD_ICU_WAIT);
    localparam logic [WAIT_W-1:0] W_STD_IO  = WAIT_W'(STD_IO_WAIT);
    localparam logic [WAIT_W-1:0] W_ALT_ROM = WAIT_W'(ALT_ROM_WAIT);
    localparam logic [WAIT_W-1:0] W_ALT_IO  = WAIT_W'(ALT_IO_WAIT);

    logic              alt_eff;
    logic              boot_q;
    region_e           region;
    logic [WAIT_W-1:0] wait_n;
    logic              ready;

    generate
        if (MAP_FROM_PIN) begin : g_map_pin
            assign alt_eff = alt_i;
        end else begin : g_map_fixed
            logic unused_alt_pin;
            assign unused_alt_pin = alt_i;
            assign alt_eff        = FIXED_ALT;
        end
    endgenerate

    bmd_region_decode u_decode (
        .addr_i   (addr_i),
        .alt_i    (alt_eff),
        .boot_i   (boot_q),
        .region_o (region)
    );

    always_comb begin
        wait_n = '0;
        unique case (region)
            RG_ROM:  wait_n = alt_eff ? W_ALT_ROM : W_STD_ROM;
            RG_ICU:  wait_n = alt_eff ? '0        : W_STD_ICU;
            RG_IO:   wait_n = alt_eff ? W_ALT_IO  : W_STD_IO;
            default: wait_n = '0;
        endcase
    end

    bmd_wait_seq #(.MAX_WAIT(MAX_WAIT)) u_wait (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cyc_i   (cyc_i),
        .wait_i  (wait_n),
        .ready_o (ready)
    );

    bmd_boot_flag u_boot (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cyc_i   (cyc_i),
        .wr_i    (wr_i),
        .ready_i (ready),
        .boot_o  (boot_q)
    );

    assign sel_rom_o = cyc_i && (region == RG_ROM);
    assign sel_icu_o = cyc_i && (region == RG_ICU);
    assign sel_io_o  = cyc_i && (region == RG_IO);
    assign sel_ram_o = cyc_i && (region == RG_RAM);
    assign ready_o   = ready;

endmodule

// File: rtl/bmd_checker.sv
module bmd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [23:0] addr,
    input logic        cyc,
    input logic        wr,
    input logic        alt,
    input logic        boot,
    input logic        sel_rom,
    input logic        sel_icu,
    input logic        sel_io,
    input logic        sel_ram,
    input logic        ready
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc |-> !(sel_rom || sel_icu || sel_io || sel_ram || ready));

    // R9
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc |-> $countones({sel_rom, sel_icu, sel_io, sel_ram}) == 1);

    // R2
    overlay_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && boot && !alt) |-> sel_rom);

    // R3
    boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boot && !(cyc && wr && ready)) |=> boot);

    // R3
    boot_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(boot) |-> $past(cyc && wr && ready));

    // R7
    nmi_not_icu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && alt && addr[8]) |-> !sel_icu);

    // R8
    alt_icu_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && alt && sel_icu) |-> ready);

    // R10
    ram_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cyc) && sel_ram) |-> ready);

endmodule

bind bootmap_decoder bmd_checker u_bmd_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .addr    (addr_i),
    .cyc     (cyc_i),
    .wr      (wr_i),
    .alt     (alt_eff),
    .boot    (boot_q),
    .sel_rom (sel_rom_o),
    .sel_icu (sel_icu_o),
    .sel_io  (sel_io_o),
    .sel_ram (sel_ram_o),
    .ready   (ready_o)
);

// File: tb/test_bootmap_decoder.sv
module test_bootmap_decoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [23:0] a_addr = '0, b_addr = '0;
    logic a_cyc = 1'b0, a_wr = 1'b0, a_alt = 1'b0;
    logic b_cyc = 1'b0, b_wr = 1'b0, b_alt = 1'b0;
    logic a_rom, a_icu, a_io, a_ram, a_rdy;
    logic b_rom, b_icu, b_io, b_ram, b_rdy;

    int tests = 0;
    int fails = 0;
    bit boot_a = 1'b1;
    bit boot_b = 1'b1;

    bootmap_decoder i_bootmap_decoder (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(a_addr), .cyc_i(a_cyc),
        .wr_i(a_wr), .alt_i(a_alt), .sel_rom_o(a_rom), .sel_icu_o(a_icu),
        .sel_io_o(a_io), .sel_ram_o(a_ram), .ready_o(a_rdy)
    );

    bootmap_decoder #(
        .MAP_FROM_PIN(1'b0), .FIXED_ALT(1'b1),
        .ALT_ROM_WAIT(0), .ALT_IO_WAIT(2)
    ) i_bootmap_decoder_fixalt (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(b_addr), .cyc_i(b_cyc),
        .wr_i(b_wr), .alt_i(b_alt), .sel_rom_o(b_rom), .sel_icu_o(b_icu),
        .sel_io_o(b_io), .sel_ram_o(b_ram), .ready_o(b_rdy)
    );

    // expected select vector {rom, icu, io, ram}
    function automatic logic [3:0] exp_sel(logic [23:0] a, bit alt, bit boot);
        if (!alt) begin
            if (boot)                                return 4'b1000;
            if (a >= 24'hFFF800)                     return 4'b0100;
            if (a >= 24'hFF0000 && a <= 24'hFF7FFF)  return 4'b1000;
            if (a >= 24'hFE0000 && a <= 24'hFFEFFF)  return 4'b0010;
            return 4'b0001;
        end
        if (a >= 24'hFFF800 && a[8] == 1'b0)         return 4'b0100;
        if (a >= 24'hC00000 && a <= 24'hC0FFFF)      return 4'b0010;
        if ((a & 24'hFB8000) == 24'h0)               return 4'b1000;
        return 4'b0001;
    endfunction

    function automatic int exp_wait(bit b, bit alt, logic [3:0] sel);
        if (sel == 4'b0001) return 0;
        if (b) return (sel == 4'b0010) ? 2 : 0;
        if (alt && sel == 4'b0100) return 0;
        return 1;
    endfunction

    function automatic logic [4:0] outs(bit b);
        return b ? {b_rom, b_icu, b_io, b_ram, b_rdy}
                 : {a_rom, a_icu, a_io, a_ram, a_rdy};
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        a_cyc = 1'b0; b_cyc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        boot_a = 1'b1; boot_b = 1'b1;
        @(negedge clk);
    endtask

    // one full bus cycle on instance b (0 = pin map, 1 = fixed alternate)
    task automatic bus(bit b, logic [23:0] a, bit wr, bit alt_pin,
                       string tsel, string twait);
        bit          alt_e = b ? 1'b1 : alt_pin;
        bit          bt = b ? boot_b : boot_a;
        logic [3:0]  es = exp_sel(a, alt_e, bt);
        int          ew = exp_wait(b, alt_e, es);
        logic [4:0]  o;
        int          first_rdy = -1;
        @(negedge clk);
        if (b) begin b_addr = a; b_wr = wr; b_alt = alt_pin; b_cyc = 1'b1; end
        else   begin a_addr = a; a_wr = wr; a_alt = alt_pin; a_cyc = 1'b1; end
        #1;
        o = outs(b);
        chk(o[4:1] == es, tsel, int'(o[4:1]), int'(es));
        for (int i = 0; i <= ew; i++) begin
            if (i > 0) begin @(negedge clk); #1; end
            o = outs(b);
            if (o[0] && first_rdy < 0) first_rdy = i;
        end
        chk(first_rdy == ew, twait, first_rdy, ew);
        @(negedge clk);
        if (b) b_cyc = 1'b0; else a_cyc = 1'b0;
        if (wr) begin if (b) boot_b = 1'b0; else boot_a = 1'b0; end
        #1;
        o = outs(b);
        chk(o == 5'b0, "R1", int'(o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1 reset state
        #1;
        chk(outs(0) == 5'b0, "R1", int'(outs(0)), 0);
        chk(outs(1) == 5'b0, "R1", int'(outs(1)), 0);

        // R2 overlay in standard map
        bus(0, 24'h000000, 0, 0, "R2", "R5");
        bus(0, 24'h123456, 0, 0, "R2", "R5");
        bus(0, 24'hFFFE00, 0, 0, "R2", "R5");
        bus(0, 24'hC00000, 0, 0, "R2", "R5");
        // R3 first write still hits PROM, then clears overlay
        bus(0, 24'h400000, 1, 0, "R3", "R5");
        bus(0, 24'h400000, 0, 0, "R3", "R10");

        // R4 / R5 standard map edges
        bus(0, 24'hFF0000, 0, 0, "R4", "R5");
        bus(0, 24'hFF7FFF, 1, 0, "R4", "R5");
        bus(0, 24'hFF8000, 0, 0, "R4", "R5");
        bus(0, 24'hFE0000, 0, 0, "R4", "R5");
        bus(0, 24'hFFEFFF, 0, 0, "R4", "R5");
        bus(0, 24'hFFF000, 0, 0, "R4", "R10");
        bus(0, 24'hFFF800, 0, 0, "R4", "R5");
        bus(0, 24'hFFFFFF, 0, 0, "R9", "R5");
        bus(0, 24'hFDFFFF, 0, 0, "R4", "R10");

        // R6 / R7 / R8 alternate map by pin (R11)
        bus(0, 24'hC00000, 0, 1, "R6", "R8");
        bus(0, 24'hC00002, 1, 1, "R6", "R8");
        bus(0, 24'h000000, 0, 1, "R6", "R8");
        bus(0, 24'h040000, 0, 1, "R6", "R8");
        bus(0, 24'h008000, 0, 1, "R6", "R10");
        bus(0, 24'h080000, 0, 1, "R6", "R10");
        bus(0, 24'hFFFE00, 0, 1, "R7", "R8");
        bus(0, 24'hFFFF00, 0, 1, "R7", "R10");
        bus(0, 24'hC10000, 0, 1, "R6", "R10");

        // R8 overlay ignored in alternate map after a fresh reset
        do_reset();
        bus(0, 24'h123456, 0, 1, "R8", "R10");
        bus(0, 24'hC00000, 0, 1, "R8", "R8");
        bus(0, 24'h123456, 0, 0, "R2", "R5");

        // R11 fixed alternate map ignores the pin; R10 two-wait path
        bus(1, 24'hC00000, 0, 0, "R11", "R10");
        bus(1, 24'h000000, 0, 0, "R11", "R10");
        bus(1, 24'hFFFE00, 0, 0, "R11", "R8");
        bus(1, 24'hFFFF00, 1, 1, "R7", "R10");
        bus(1, 24'hC0FFFE, 1, 0, "R6", "R10");

        // random mix, R9 and R10 across all regions
        for (int n = 0; n < 400; n++) begin
            logic [23:0] ad;
            bit          wr, alt, which;
            logic [23:0] base [8] = '{24'h000000, 24'h040000, 24'hC00000, 24'hFE0000,
                                      24'hFF0000, 24'hFF8000, 24'hFFF000, 24'hFFF800};
            ad = base[$urandom % 8] | 24'($urandom % 24'h10000);
            if ($urandom % 4 == 0) ad = 24'($urandom);
            wr    = ($urandom % 6) == 0;
            alt   = $urandom % 2;
            which = ($urandom % 3) == 0;
            if ($urandom % 50 == 0) do_reset();
            bus(which, ad, wr, alt, "R9", "R10");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule